// File: doc/BRIEF.md
# Cartridge Bridge Register Interface

This block sits between a host peripheral bus and a plugged-in cartridge that has a 16-bit address space. The host sends byte requests: a read or a write at a 16-bit address. The top four address bits pick one of four places:

- a power register that turns the bridge on and off;
- a bank register;
- a status/control register;
- a 16 KiB window onto the cartridge.

Window accesses go out on a separate cartridge request port, with the address translated through the current bank. Read data from the cartridge is relayed back to the host.

The host request channel is valid/ready. `req_ready` is high only while the bridge is idle. It drops from the accepting edge of a live window access until the cartridge accepts that access and, for a read, returns data. A read gets exactly one `rsp_valid` pulse carrying `rsp_data`. The host must take it, because the response has no back-pressure. Writes get no response.

The cartridge request port is also valid/ready. While `cart_req_valid` is high, its request fields hold steady until `cart_req_ready` accepts them. After accepting a read, the cartridge answers with a one-cycle `cart_rsp_valid`. A multi-byte host write arrives as consecutive beats, and `req_last` marks the final beat.

The bridge keeps four pieces of state:

- a bridge-enable flag;
- a 2-bit bank;
- a cartridge-enable flag;
- a 2-bit reset-progress counter.

The counter advances only when the status register is read. It resets to 3, and the bridge and cartridge flags and the bank reset to 0.

Top module: `cart_bridge`

## Requirements
- R1: Address bits [15:12] select the region: 0x8 power, 0xA bank, 0xB status, 0xC to 0xF window. A power-register read returns 0x84 when the bridge is enabled and 0x00 when it is disabled, and it works in both states.
- R2: A power-register write of 0xFE disables the bridge and a write of 0x84 enables it. Any other value leaves the bridge state unchanged.
- R3: A 0x84 power write while the bridge is disabled also sets the bank to 3, clears the reset-progress counter to 0 and clears cartridge-enable. The same write while the bridge is already enabled changes none of these.
- R4: While the bridge is disabled, every access outside the power region is ignored: no state changes, no cartridge request is issued, and any read returns 0x00.
- R5: A bank-register write stores the written value when it is 3 or less, and stores 0 for any larger value.
- R6: A status write with bit0 = 1 sets cartridge-enable. If cartridge-enable was clear, the same write also loads the counter with 3 and pulses `cart_bank_reset` high for exactly one cycle. A status write with bit0 = 0 clears cartridge-enable.
- R7: A status read returns cartridge-enable in bit0, the counter in bits [3:2] and bridge-enable in bit7. All other bits read as 0. The value returned is the one from before the read's own counter update.
- R8: Each status read moves the counter as follows; in every other case it holds:
  - from 3 to 2 when cartridge-enable is set;
  - from 2 to 1 when cartridge-enable is clear;
  - from 1 to 0 when cartridge-enable is clear.
- R9: A window access goes to cartridge address 0x4000·bank + (addr & 0x7FFF) − 0x4000, truncated to 16 bits, which equals {bank, addr[13:0]}. The data from a window read is returned unchanged on `rsp_data`.
- R10: For register writes only the beat flagged by `req_last` takes effect, and earlier beats change nothing. Every beat of a window write is forwarded to the cartridge.
- R11: With `cart_present` low, a window read returns 0x00 and a window write issues no cartridge request. A read of an undecoded region returns 0x00.
- R12: After reset `req_ready` is high and `rsp_valid`, `cart_req_valid` and `cart_bank_reset` are low. `req_ready` is low while a cartridge request is outstanding. A stalled cartridge request keeps its address and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_last | input | 1 | Final beat of a write |
| req_addr | input | 16 | Host address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 8 | Read data |
| cart_present | input | 1 | A cartridge is plugged in |
| cart_req_valid | output | 1 | Cartridge request valid |
| cart_req_ready | input | 1 | Cartridge accepts request |
| cart_req_write | output | 1 | Cartridge request is a write |
| cart_addr | output | 16 | Translated cartridge address |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rsp_valid | input | 1 | Cartridge read data valid |
| cart_rsp_data | input | 8 | Cartridge read data |
| cart_bank_reset | output | 1 | One-cycle request to reset cartridge banking |

## Verification
The hardest behaviour to reach is the full reset-progress walk, 3 to 2 to 1 to 0. It needs a fixed order of steps:

1. enable the bridge;
2. enable the cartridge by a status write;
3. read the status register while the cartridge is enabled;
4. disable the cartridge by a status write;
5. read the status register twice more.

Any stray enable write in between restarts the walk. A directed sequence drives this order and checks every step. A long random run then mixes power, bank, status and window traffic, multi-beat writes, stalls and gaps on the cartridge handshake, and cartridge removal. That run reaches the rarer orderings, such as re-enabling an already enabled bridge, or a status write with bit0 set while the cartridge is already enabled.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    RG_POWER,
    RG_BANK,
    RG_STAT,
    RG_WIN,
    RG_NONE
  } region_e;

  localparam logic [7:0] PWR_ON_CODE  = 8'h84;
  localparam logic [7:0] PWR_OFF_CODE = 8'hFE;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [3:0] nib,
  output region_e    region
);
  always_comb begin
    unique case (nib)
      4'h8:                      region = RG_POWER;
      4'hA:                      region = RG_BANK;
      4'hB:                      region = RG_STAT;
      4'hC, 4'hD, 4'hE, 4'hF:    region = RG_WIN;
      default:                   region = RG_NONE;
    endcase
  end
endmodule

// File: rtl/cbr_xlate.sv
module cbr_xlate #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cart_addr
);
  localparam int WIN_W = ADDR_W - BANK_W;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << (WIN_W + 1)) - 1);
  localparam logic [ADDR_W:0]   WIN_BASE = (ADDR_W+1)'(1) << WIN_W;

  logic [ADDR_W:0] base_w, off_w, sum_w;

  // bank * window size + (addr masked to two windows) - one window
  assign base_w    = {1'b0, bank, {WIN_W{1'b0}}};
  assign off_w     = {1'b0, addr & OFF_MASK};
  assign sum_w     = base_w + off_w - WIN_BASE;
  assign cart_addr = sum_w[ADDR_W-1:0];
endmodule

// File: rtl/cbr_regs.sv
module cbr_regs
  import cbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic              last,
  input  region_e           region,
  input  logic [DATA_W-1:0] wdata,
  output logic              bridge_en,
  output logic [BANK_W-1:0] bank,
  output logic              cart_en,
  output logic [CNT_W-1:0]  rst_cnt,
  output logic              bank_reset,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] BANK_MAX = DATA_W'((1 << BANK_W) - 1);
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'((1 << CNT_W) - 1);

  logic wr_eff;
  assign wr_eff = acc && wr && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bridge_en  <= 1'b0;
      bank       <= '0;
      cart_en    <= 1'b0;
      rst_cnt    <= CNT_TOP;
      bank_reset <= 1'b0;
    end else begin
      bank_reset <= 1'b0;
      unique case (region)
        RG_POWER: begin
          if (wr_eff && wdata == DATA_W'(PWR_ON_CODE)) begin
            if (!bridge_en) begin
              bank    <= BANK_W'(3);
              rst_cnt <= '0;
              cart_en <= 1'b0;
            end
            bridge_en <= 1'b1;
          end else if (wr_eff && wdata == DATA_W'(PWR_OFF_CODE)) begin
            bridge_en <= 1'b0;
          end
        end
        RG_BANK: begin
          if (wr_eff && bridge_en)
            bank <= (wdata > BANK_MAX) ? '0 : wdata[BANK_W-1:0];
        end
        RG_STAT: begin
          if (wr_eff && bridge_en) begin
            if (wdata[0]) begin
              if (!cart_en) begin
                rst_cnt    <= CNT_TOP;
                bank_reset <= 1'b1;
              end
              cart_en <= 1'b1;
            end else begin
              cart_en <= 1'b0;
            end
          end else if (acc && !wr && bridge_en) begin
            if (cart_en && rst_cnt == CNT_W'(3))
              rst_cnt <= CNT_W'(2);
            else if (!cart_en && rst_cnt == CNT_W'(2))
              rst_cnt <= CNT_W'(1);
            else if (!cart_en && rst_cnt == CNT_W'(1))
              rst_cnt <= CNT_W'(0);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (region == RG_POWER) begin
      rdata = bridge_en ? DATA_W'(PWR_ON_CODE) : '0;
    end else if (region == RG_STAT && bridge_en) begin
      rdata[7]   = 1'b1;
      rdata[3:2] = rst_cnt;
      rdata[0]   = cart_en;
    end
  end
endmodule

// File: rtl/cart_bridge.sv
module cart_bridge
  import cbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              cart_present,
  output logic              cart_req_valid,
  input  logic              cart_req_ready,
  output logic              cart_req_write,
  output logic [ADDR_W-1:0] cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  input  logic              cart_rsp_valid,
  input  logic [DATA_W-1:0] cart_rsp_data,
  output logic              cart_bank_reset
);
  typedef enum logic [1:0] {ST_IDLE, ST_CREQ, ST_CRSP} state_e;

  state_e            state_q;
  region_e           region;
  logic              hs, win_live;
  logic              bridge_en, cart_en_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] reg_rdata;
  logic [ADDR_W-1:0] xl_addr;

  cbr_decode u_dec (
    .nib    (req_addr[ADDR_W-1 -: 4]),
    .region (region)
  );

  cbr_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_xl (
    .bank      (bank_q),
    .addr      (req_addr),
    .cart_addr (xl_addr)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign hs        = req_valid && req_ready;
  assign win_live  = (region == RG_WIN) && bridge_en && cart_present;

  cbr_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (hs && region != RG_WIN),
    .wr         (req_write),
    .last       (req_last),
    .region     (region),
    .wdata      (req_wdata),
    .bridge_en  (bridge_en),
    .bank       (bank_q),
    .cart_en    (cart_en_q),
    .rst_cnt    (cnt_q),
    .bank_reset (cart_bank_reset),
    .rdata      (reg_rdata)
  );

  assign cart_req_valid = (state_q == ST_CREQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      cart_req_write <= 1'b0;
      cart_addr      <= '0;
      cart_wdata     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hs) begin
            if (win_live) begin
              cart_req_write <= req_write;
              cart_addr      <= xl_addr;
              cart_wdata     <= req_wdata;
              state_q        <= ST_CREQ;
            end else if (!req_write) begin
              rsp_valid <= 1'b1;
              rsp_data  <= reg_rdata;
            end
          end
        end
        ST_CREQ: begin
          if (cart_req_ready)
            state_q <= cart_req_write ? ST_IDLE : ST_CRSP;
        end
        ST_CRSP: begin
          if (cart_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= cart_rsp_data;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cart_bridge_chk.sv
module cart_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cart_req_valid,
  input logic              cart_req_ready,
  input logic [ADDR_W-1:0] cart_addr,
  input logic              cart_bank_reset,
  input logic [BANK_W-1:0] bank,
  input logic [CNT_W-1:0]  rst_cnt
);
  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cart_req_valid && !cart_req_ready |=> cart_req_valid && $stable(cart_addr));

  assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cart_req_valid));

  assert_win_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cart_req_valid) |-> $past(req_valid && req_ready && req_addr[ADDR_W-1 -: 2] == 2'b11));

  assert_bank_in_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cart_req_valid |-> cart_addr[ADDR_W-1 -: BANK_W] == bank);

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cart_bank_reset |-> $past(req_valid && req_ready && req_write && req_addr[ADDR_W-1 -: 4] == 4'hB));

  assert_cnt_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rst_cnt) |-> $past(req_valid && req_ready &&
      (req_addr[ADDR_W-1 -: 4] == 4'hB || req_addr[ADDR_W-1 -: 4] == 4'h8)));
endmodule

bind cart_bridge cart_bridge_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_write       (req_write),
  .req_addr        (req_addr),
  .cart_req_valid  (cart_req_valid),
  .cart_req_ready  (cart_req_ready),
  .cart_addr       (cart_addr),
  .cart_bank_reset (cart_bank_reset),
  .bank            (bank_q),
  .rst_cnt         (cnt_q)
);

// File: tb/cart_bridge_tb.sv
module cart_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_last = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic        cart_present = 1'b1;
  logic        cart_req_valid, cart_req_write, cart_bank_reset;
  logic        cart_req_ready = 1'b0;
  logic [15:0] cart_addr;
  logic [7:0]  cart_wdata;
  logic        cart_rsp_valid = 1'b0;
  logic [7:0]  cart_rsp_data = '0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cart_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_last(req_last), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cart_present(cart_present),
    .cart_req_valid(cart_req_valid), .cart_req_ready(cart_req_ready),
    .cart_req_write(cart_req_write), .cart_addr(cart_addr), .cart_wdata(cart_wdata),
    .cart_rsp_valid(cart_rsp_valid), .cart_rsp_data(cart_rsp_data),
    .cart_bank_reset(cart_bank_reset)
  );

  // reference state
  logic       m_en = 0, m_cen = 0;
  logic [1:0] m_bank = 0, m_cnt = 3;
  int         m_pulses = 0;

  // cartridge-side observations
  int          cart_wr_cnt = 0, cart_rd_cnt = 0, pulses = 0;
  logic [15:0] cart_last_waddr = 0, cart_last_raddr = 0;
  logic [7:0]  cart_last_wdata = 0;

  function automatic logic [7:0] cart_fn(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // cartridge model
  initial begin
    logic        pv = 0, pr = 0, pw = 0;
    logic [15:0] pa = 0;
    logic [7:0]  pd = 0;
    int          dly = -1;
    logic [15:0] rd_a = 0;
    forever begin
      @(negedge clk);
      cart_rsp_valid = 1'b0;
      if (pv && pr) begin
        if (pw) begin
          cart_wr_cnt++; cart_last_waddr = pa; cart_last_wdata = pd;
        end else begin
          cart_rd_cnt++; cart_last_raddr = pa; rd_a = pa; dly = int'($urandom % 3);
        end
      end else if (dly > 0) dly--;
      else if (dly == 0) begin
        cart_rsp_valid = 1'b1; cart_rsp_data = cart_fn(rd_a); dly = -1;
      end
      if (cart_bank_reset) pulses++;
      cart_req_ready = ($urandom % 3) != 0;
      pv = cart_req_valid; pr = cart_req_ready; pw = cart_req_write;
      pa = cart_addr; pd = cart_wdata;
    end
  end

  task automatic bus_op(logic wr, logic [15:0] a, logic [7:0] d, logic last, string tag);
    logic [7:0] exp_rd = 8'h00;
    int  exp_wr = cart_wr_cnt, exp_rdc = cart_rd_cnt;
    logic win = (a[15:14] == 2'b11);
    logic live = win && m_en && cart_present;
    logic [15:0] exp_ca = {m_bank, a[13:0]};
    int guard;
    // reference update
    if (a[15:12] == 4'h8) begin
      if (!wr) exp_rd = m_en ? 8'h84 : 8'h00;
      else if (last && d == 8'h84) begin
        if (!m_en) begin m_bank = 3; m_cnt = 0; m_cen = 0; end
        m_en = 1;
      end else if (last && d == 8'hFE) m_en = 0;
    end else if (m_en) begin
      if (a[15:12] == 4'hA && wr && last) m_bank = (d > 3) ? 2'd0 : d[1:0];
      else if (a[15:12] == 4'hB) begin
        if (!wr) begin
          exp_rd = {1'b1, 3'b000, m_cnt, 1'b0, m_cen};
          if (m_cen && m_cnt == 3) m_cnt = 2;
          else if (!m_cen && m_cnt == 2) m_cnt = 1;
          else if (!m_cen && m_cnt == 1) m_cnt = 0;
        end else if (last) begin
          if (d[0]) begin
            if (!m_cen) begin m_cnt = 3; m_pulses++; end
            m_cen = 1;
          end else m_cen = 0;
        end
      end
    end
    if (live) begin
      if (wr) exp_wr++; else begin exp_rdc++; exp_rd = cart_fn(exp_ca); end
    end
    // drive
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_last = last;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!wr) begin
      guard = 0;
      while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
      check({tag, " read data"}, {8'h00, rsp_data}, {8'h00, exp_rd});
    end
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    if (live) begin
      if (wr) begin
        check("R9 window write address", cart_last_waddr, exp_ca);
        check("R10 window write data", {8'h00, cart_last_wdata}, {8'h00, d});
      end else
        check("R9 window read address", cart_last_raddr, exp_ca);
    end
    if (win) begin
      check({tag, " cart writes"}, 16'(cart_wr_cnt), 16'(exp_wr));
      check({tag, " cart reads"}, 16'(cart_rd_cnt), 16'(exp_rdc));
    end
    check("R6 reset pulses", 16'(pulses), 16'(m_pulses));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 reset req_ready", {15'd0, req_ready}, 16'd1);
    check("R12 reset rsp_valid", {15'd0, rsp_valid}, 16'd0);
    check("R12 reset cart_req_valid", {15'd0, cart_req_valid}, 16'd0);
    check("R12 reset cart_bank_reset", {15'd0, cart_bank_reset}, 16'd0);

    bus_op(0, 16'h8000, 0, 1, "R1 power read disabled");
    bus_op(0, 16'hB000, 0, 1, "R4 status read disabled");
    bus_op(1, 16'hB000, 8'h01, 1, "R4 status write disabled");
    bus_op(0, 16'hC010, 0, 1, "R4 window read disabled");
    bus_op(1, 16'hD020, 8'h11, 1, "R4 window write disabled");
    bus_op(1, 16'h8000, 8'h12, 1, "R2 power other value");
    bus_op(0, 16'h8000, 0, 1, "R2 power read after other");
    bus_op(1, 16'h8000, 8'h84, 1, "R3 enable");
    bus_op(0, 16'h8FFF, 0, 1, "R1 power read enabled");
    bus_op(0, 16'hB000, 0, 1, "R3 R7 status after enable");
    bus_op(0, 16'hFFFF, 0, 1, "R3 window bank 3");
    bus_op(1, 16'hB000, 8'h01, 1, "R6 cart enable");
    bus_op(0, 16'hB000, 0, 1, "R8 count 3");
    bus_op(1, 16'hB000, 8'h03, 1, "R6 enable again no pulse");
    bus_op(1, 16'hB000, 8'h00, 1, "R6 cart disable");
    bus_op(0, 16'hB000, 0, 1, "R8 count 2");
    bus_op(0, 16'hB000, 0, 1, "R8 count 1");
    bus_op(0, 16'hB000, 0, 1, "R8 count 0 hold");
    bus_op(1, 16'hA000, 8'h07, 1, "R5 bank over range");
    bus_op(0, 16'hC123, 0, 1, "R5 window bank 0");
    bus_op(1, 16'hA000, 8'h03, 0, "R10 nonlast beat");
    bus_op(1, 16'hA000, 8'h02, 1, "R10 last beat");
    bus_op(0, 16'hE456, 0, 1, "R5 R9 window bank 2");
    bus_op(1, 16'hC001, 8'hA1, 0, "R10 window beat 1");
    bus_op(1, 16'hC001, 8'hA2, 1, "R10 window beat 2");
    bus_op(1, 16'h8000, 8'h84, 1, "R3 enable when enabled");
    bus_op(0, 16'hC000, 0, 1, "R3 bank kept");
    bus_op(0, 16'h1234, 0, 1, "R11 undecoded read");
    cart_present = 0;
    bus_op(0, 16'hC777, 0, 1, "R11 no cart read");
    bus_op(1, 16'hC777, 8'h55, 1, "R11 no cart write");
    cart_present = 1;
    bus_op(1, 16'h8000, 8'hFE, 1, "R2 disable");
    bus_op(0, 16'h8000, 0, 1, "R2 power read after disable");

    for (int i = 0; i < 1500; i++) begin
      logic [3:0]  nib;
      logic [15:0] a;
      logic [7:0]  d;
      int          sel = int'($urandom % 10);
      nib = (sel < 2) ? 4'h8 : (sel < 3) ? 4'hA : (sel < 5) ? 4'hB :
            (sel < 9) ? 4'hC + 4'($urandom % 4) : 4'($urandom % 8);
      a = {nib, 12'($urandom)};
      d = 8'($urandom);
      if (nib == 4'h8 && ($urandom % 2)) d = ($urandom % 2) ? 8'h84 : 8'hFE;
      if (nib == 4'hA && ($urandom % 2)) d = 8'($urandom % 4);
      if (($urandom % 40) == 0) cart_present = ~cart_present;
      bus_op(1'($urandom % 2), a, d, ($urandom % 4) != 0, "R1 R4 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule